// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Receiver

This block receives asynchronous serial characters on a single input line. A one-cycle tick arrives at sixteen times the bit rate, and the line is sampled on each tick after a two-stage synchronizer. Every bit period is divided into sub-samples 1 to 16. The start, data and stop bits are each decided by a two-out-of-three vote over sub-samples 8, 9 and 10. A start bit that loses the vote is treated as a noise spike. An accepted character is always delivered to a holding register, even when its stop bit is bad, and a framing-error flag then marks it.

The frame has one start bit (low), eight data bits sent least significant bit first, and one stop bit (high), with no parity. A host read strobe clears the receive-complete and overrun flags. The framing-error flag describes the byte currently held.

The engine has four states. In IDLE, a low sample on a tick moves the engine to START and sets the sub-sample counter to 1. START returns to IDLE when the vote at sub-sample 10 is high (noise). Otherwise START moves to DATA at the end of sub-sample 16. DATA shifts in one voted bit per bit period and moves to STOP after the eighth bit. STOP delivers the character at its sub-sample 10 vote and returns to IDLE at once, so the next falling edge can be caught straight away.

Top module: `uart_vote_rx`

## Requirements
- R1: The line passes through a two-flip-flop synchronizer and is sampled only on clock edges where `tick` is high. One bit period is 16 ticks.
- R2: In IDLE, a single low synchronized sample on a tick starts start-bit checking, and that tick counts as sub-sample 1.
- R3: The start bit is voted at sub-samples 8, 9 and 10. If two or more are high, the engine returns to IDLE, delivers nothing and hunts for the next falling edge. If two or more are low, the start bit is accepted.
- R4: Each data bit takes the level seen in at least two of its sub-samples 8, 9 and 10. Samples at sub-samples 1 to 7 and 11 to 16 have no effect on the bit.
- R5: Exactly 8 data bits follow the start bit, least significant bit first. Each voted bit is shifted in when its vote completes.
- R6: The stop bit is accepted when two or more of its sub-samples 8, 9 and 10 are high. Otherwise `frame_err` is 1 for that byte.
- R7: At the stop bit's sub-sample 10, the byte is copied to `rx_data` and `rx_valid` is set, whether or not the stop bit was valid.
- R8: A one-cycle `rd_stb` clears `rx_valid` and `overrun`.
- R9: `frame_err` changes only when a new byte is transferred. A read does not change it.
- R10: If a byte completes while `rx_valid` is 1 and no read occurs in that cycle, `overrun` is set and the new byte replaces the held one.
- R11: After the stop-bit vote the engine is in IDLE, so a start bit that begins at the stop bit's sub-sample 11 is received.
- R12: Reset clears `rx_data` and all flags and drops any partly received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rd_stb | input | 1 | Host read strobe, clears `rx_valid` and `overrun` |
| rx_data | output | 8 | Holding register with the last received byte |
| rx_valid | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Stop bit of the held byte failed its vote |
| overrun | output | 1 | A byte was replaced before it was read |

## Verification
Clean frames establish the bit order and the delivery timing. Frames with a single flipped sample inside the 8 to 10 window, and frames with flips everywhere outside it, show that the vote rather than one sample decides each bit. Frames with two flipped samples inside the window must invert every bit, which separates a true majority from a single centre sample. Short low pulses and start bits that lose the vote separate noise rejection from edge detection. Bad, marginal and shortened stop bits, and pairs of unread frames, exercise the framing-error, re-hunting and overrun rules.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rxv_sampler.sv
module rxv_sampler #(
    parameter int OVS = 16,
    parameter int MID = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic run,
    input  logic rx,
    output logic vote_now,
    output logic vote_bit,
    output logic bit_last
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] P_A   = PW'(MID - 2);
    localparam logic [PW-1:0] P_B   = PW'(MID - 1);
    localparam logic [PW-1:0] P_C   = PW'(MID);
    localparam logic [PW-1:0] P_END = PW'(OVS - 1);

    logic [PW-1:0] phase, phase_nx;
    logic          s_a, s_b;

    assign phase_nx = (phase == P_END) ? '0 : phase + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            s_a   <= 1'b1;
            s_b   <= 1'b1;
        end else if (arm) begin
            phase <= '0;
        end else if (run && tick) begin
            phase <= phase_nx;
            if (phase_nx == P_A) s_a <= rx;
            if (phase_nx == P_B) s_b <= rx;
        end
    end

    assign vote_now = run && tick && (phase_nx == P_C);
    assign vote_bit = (s_a & s_b) | (s_a & rx) | (s_b & rx);
    assign bit_last = run && tick && (phase_nx == P_END);

    // R2: the edge that arms the counter only arrives while the engine is idle
    assert_arm_while_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !run);
endmodule

// File: rtl/rxv_fsm.sv
module rxv_fsm
    import uart_rx_pkg::*;
#(
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    input  logic             vote_now,
    input  logic             vote_bit,
    input  logic             bit_last,
    output logic             arm,
    output logic             run,
    output logic             done,
    output logic             stop_ok,
    output logic [DBITS-1:0] data
);
    localparam int CW = (DBITS > 1) ? $clog2(DBITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DBITS - 1);

    rx_state_e         state, nxt;
    logic [CW-1:0]     bitcnt;
    logic [DBITS-1:0]  shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rx) nxt = RX_START;
            RX_START: if (vote_now && vote_bit) nxt = RX_IDLE;
                      else if (bit_last)        nxt = RX_DATA;
            RX_DATA:  if (bit_last && bitcnt == LAST) nxt = RX_STOP;
            RX_STOP:  if (vote_now) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_comb begin
        arm     = (state == RX_IDLE) && tick && !rx;
        run     = (state != RX_IDLE);
        done    = (state == RX_STOP) && vote_now;
        stop_ok = vote_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
        end else begin
            if (state == RX_START && bit_last) bitcnt <= '0;
            else if (state == RX_DATA && bit_last && bitcnt != LAST) bitcnt <= bitcnt + 1'b1;
            if (state == RX_DATA && vote_now) shreg <= {vote_bit, shreg[DBITS-1:1]};
        end
    end

    assign data = shreg;

    // R2: entry into START follows a low sample taken on a tick
    assert_start_on_low_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && $past(state) == RX_IDLE) |-> ($past(tick) && !$past(rx)));
    // R3: a start bit that votes high is dropped
    assert_noise_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && vote_now && vote_bit) |=> state == RX_IDLE);
    // R5: the stop bit is only reached through the data bits
    assert_stop_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && $past(state) != RX_STOP) |-> $past(state) == RX_DATA);
    // R11: the stop decision puts the engine straight back in IDLE
    assert_idle_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state == RX_IDLE);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
    parameter int DBITS   = 8,
    parameter int OVS     = 16,
    parameter int MID     = 9,
    parameter int SYNC_FF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_in,
    input  logic             rd_stb,
    output logic [DBITS-1:0] rx_data,
    output logic             rx_valid,
    output logic             frame_err,
    output logic             overrun
);
    logic             rx_s, arm, run, done, stop_ok;
    logic             vote_now, vote_bit, bit_last;
    logic [DBITS-1:0] shreg;

    rxv_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    rxv_sampler #(.OVS(OVS), .MID(MID)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .run(run), .rx(rx_s),
        .vote_now(vote_now), .vote_bit(vote_bit), .bit_last(bit_last)
    );

    rxv_fsm #(.DBITS(DBITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .vote_now(vote_now), .vote_bit(vote_bit), .bit_last(bit_last),
        .arm(arm), .run(run), .done(done), .stop_ok(stop_ok), .data(shreg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else if (done) begin
            rx_data   <= shreg;
            rx_valid  <= 1'b1;
            frame_err <= !stop_ok;
            overrun   <= rx_valid && !rd_stb;
        end else if (rd_stb) begin
            rx_valid  <= 1'b0;
            overrun   <= 1'b0;
        end
    end

    // R7: every completed character raises the receive-complete flag
    assert_valid_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_valid);
    // R8: a read without a new byte clears the flags
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> (!rx_valid && !overrun));
    // R9: the framing flag only moves with a transfer
    assert_fe_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(frame_err));
    // R10: an unread byte that gets replaced flags an overrun
    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_valid && !rd_stb) |=> overrun);
endmodule

// File: tb/sim_uart_vote_rx.sv
module sim_uart_vote_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       rd_auto = 1'b0;
    logic       rd_man = 1'b0;
    logic       rd_stb;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, overrun;
    logic       auto_read = 1'b1;
    logic       finished = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    typedef struct packed { logic [7:0] d; logic fe; } exp_t;
    exp_t exp_q[$];

    assign rd_stb = rd_auto | rd_man;

    always #10 clk = ~clk;

    uart_vote_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // one sub-sample slot: line set, tick three clocks later
    task automatic slot(input logic v);
        rx = v;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic send_bit(input logic v, input logic [15:0] m, input int len);
        for (int s = 0; s < len; s++) slot(v ^ m[s]);
    endtask

    task automatic frame(input logic [7:0] d, input logic [15:0] stm, input logic [15:0] dm,
                         input logic stop_v, input logic [15:0] sm, input int stop_len,
                         input int idle, input bit push);
        exp_t e;
        for (int i = 0; i < 8; i++) e.d[i] = maj3(d[i] ^ dm[7], d[i] ^ dm[8], d[i] ^ dm[9]);
        e.fe = !maj3(stop_v ^ sm[7], stop_v ^ sm[8], stop_v ^ sm[9]);
        if (push) exp_q.push_back(e);
        send_bit(1'b0, stm, 16);
        for (int i = 0; i < 8; i++) send_bit(d[i], dm, 16);
        send_bit(stop_v, sm, stop_len);
        send_bit(1'b1, 16'h0, idle);
    endtask

    task automatic read_pulse();
        rd_man = 1'b1;
        @(negedge clk);
        rd_man = 1'b0;
        @(negedge clk);
    endtask

    // scoreboard monitor: pops an expected byte each time one is delivered
    always @(negedge clk) begin
        rd_auto <= 1'b0;
        if (rst_n && auto_read && rx_valid && !rd_auto) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", {8'h0, rx_data}, 16'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rx_data == e.d, "R4/R5/R7 data", {8'h0, rx_data}, {8'h0, e.d});
                chk(frame_err == e.fe, "R6 frame_err", {15'h0, frame_err}, {15'h0, e.fe});
                chk(overrun == 1'b0, "R10 no overrun", {15'h0, overrun}, 16'h0);
            end
            rd_auto <= 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(rx_data == 8'h00 && !rx_valid && !frame_err && !overrun, "R12 reset state",
            {rx_valid, frame_err, overrun, 5'h0, rx_data}, 16'h0);
        rst_n = 1'b1;
        send_bit(1'b1, 16'h0, 20);

        // R1/R5/R7 clean frame
        frame(8'hA5, 16'h0, 16'h0, 1'b1, 16'h0, 16, 12, 1);
        // R4 single flipped sample at sub 9 keeps the bit
        frame(8'h3C, 16'h0, 16'h0100, 1'b1, 16'h0, 16, 12, 1);
        // R4 flips outside 8..10 ignored
        frame(8'h0F, 16'h0, 16'hFC7F, 1'b1, 16'h0, 16, 12, 1);
        // R4 two flips at subs 8,9 invert every bit
        frame(8'h5A, 16'h0, 16'h0180, 1'b1, 16'h0, 16, 12, 1);
        // R3 start with one high sample at sub 10 is still valid
        frame(8'hC3, 16'h0200, 16'h0, 1'b1, 16'h0, 16, 12, 1);

        // R3 short low spike rejected
        send_bit(1'b0, 16'h0, 3);
        send_bit(1'b1, 16'h0, 24);
        chk(!rx_valid && exp_q.size() == 0, "R3 spike dropped", {15'h0, rx_valid}, 16'h0);
        // R3 start that votes high at subs 8,9 rejected
        send_bit(1'b0, 16'h0, 7);
        slot(1'b1); slot(1'b1); slot(1'b0);
        send_bit(1'b1, 16'h0, 24);
        chk(!rx_valid && exp_q.size() == 0, "R3 start vote high", {15'h0, rx_valid}, 16'h0);
        // R2 next edge still found
        frame(8'h81, 16'h0, 16'h0, 1'b1, 16'h0, 16, 12, 1);

        // R6/R7 bad stop still delivers
        frame(8'h6E, 16'h0, 16'h0, 1'b0, 16'h0, 16, 14, 1);
        // R6 stop with one low sample at sub 9 accepted
        frame(8'h27, 16'h0, 16'h0, 1'b1, 16'h0100, 16, 12, 1);
        // R11 back-to-back frames with stop cut to 10 sub-samples
        frame(8'h12, 16'h0, 16'h0, 1'b1, 16'h0, 10, 0, 1);
        frame(8'hED, 16'h0, 16'h0, 1'b1, 16'h0, 10, 12, 1);
        chk(exp_q.size() == 0, "R11 both frames received", 16'(exp_q.size()), 16'h0);

        // manual reads from here
        auto_read = 1'b0;
        @(negedge clk);
        frame(8'h99, 16'h0, 16'h0, 1'b0, 16'h0, 16, 14, 0);
        chk(rx_valid && frame_err && rx_data == 8'h99, "R6/R7 manual bad stop",
            {rx_valid, frame_err, 6'h0, rx_data}, {2'b11, 6'h0, 8'h99});
        read_pulse();
        chk(!rx_valid, "R8 read clears rx_valid", {15'h0, rx_valid}, 16'h0);
        chk(frame_err, "R9 frame_err kept over read", {15'h0, frame_err}, 16'h1);
        frame(8'h44, 16'h0, 16'h0, 1'b1, 16'h0, 16, 12, 0);
        chk(!frame_err && !overrun, "R9 frame_err updated on transfer",
            {14'h0, frame_err, overrun}, 16'h0);
        // R10 overrun: second byte while first unread
        frame(8'h77, 16'h0, 16'h0, 1'b1, 16'h0, 16, 12, 0);
        chk(overrun && rx_valid && rx_data == 8'h77, "R10 overrun and replace",
            {overrun, rx_valid, 6'h0, rx_data}, {2'b11, 6'h0, 8'h77});
        read_pulse();
        chk(!overrun && !rx_valid, "R8 read clears overrun", {14'h0, overrun, rx_valid}, 16'h0);

        // R12 reset during a character
        auto_read = 1'b1;
        send_bit(1'b0, 16'h0, 16);
        send_bit(1'b1, 16'h0, 16);
        send_bit(1'b0, 16'h0, 16);
        send_bit(1'b0, 16'h0, 8);
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_data == 8'h00 && !rx_valid && !frame_err && !overrun, "R12 mid-frame reset",
            {rx_valid, frame_err, overrun, 5'h0, rx_data}, 16'h0);
        rst_n = 1'b1;
        send_bit(1'b1, 16'h0, 30);
        chk(!rx_valid && exp_q.size() == 0, "R12 partial character dropped", {15'h0, rx_valid}, 16'h0);
        frame(8'h3E, 16'h0, 16'h0, 1'b1, 16'h0, 16, 12, 1);
        chk(exp_q.size() == 0, "R12 receive after reset", 16'(exp_q.size()), 16'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule